// File: doc/BRIEF.md
# Configuration Fuse and Lock Controller

This block holds a chip's non-volatile configuration word and its two lock bits, together with small register arrays that stand in for program memory and data memory. Three programming ports reach it: a parallel port, a JTAG port and a serial in-system-programming (ISP) port. Each port issues one command at a time. The command set covers reading and writing the fuse word, reading and writing either memory, programming the lock bits and erasing the chip. Every command gets a one-cycle done pulse with an accept or refuse status.

The controller enforces the protection rules. A port can be disabled by its own enable fuse, and then only another port can turn it back on. A locked device refuses memory access and fuse writes, but it still allows fuse reads. Chip erase is the only way to unlock, and it never touches the fuses. The fuse word is also decoded into registered outputs for the rest of the chip: clock source, start-up delay, watchdog force, reset vector and compatibility mode.

A fuse bit follows the programmed-is-zero convention: 0 enables the feature and 1 disables it.

Top module: `cfg_fuse_ctrl`

## Requirements
- R1: After reset the fuse word reads 16'hF1E1 and the lock bits read 2'b11. The decoded outputs are clk_src=4'b0001, start_dly=2'b10, wdt_force=0, reset_vec=0 and compat_mode=1. No done is asserted.
- R2: Fuse word fields are: bits 3:0 clock select, 5:4 start-up select, 6 reset-pin-as-I/O (0=programmed), 7 watchdog-always-on, 8 boot-reset, 9 JTAG-disable, 10 ISP-disable, 11 compatibility, 15:12 spare (always read 1). The decoded outputs follow a completed fuse write one cycle after its done pulse, and not before.
- R3: Port indices are 0=parallel, 1=JTAG, 2=ISP. When several ports request together, the lowest index is served first, and only one command executes per cycle. Done for a command rises one cycle after its request is served, and lasts one cycle. ok is never high without done.
- R4: A refused command changes no fuse, lock or memory state, and returns rdata=0.
- R5: The device is locked whenever the lock bits differ from 2'b11. While locked, memory reads, memory writes and fuse writes are refused. Fuse reads, lock writes and chip erase are still accepted. A lock write ANDs bits 1:0 of wdata into the lock bits.
- R6: Chip erase sets both memories to all zero and the lock bits to 2'b11, and leaves the fuse word unchanged.
- R7: Every ISP command is refused while fuse bit 10 is 1 or fuse bit 6 is 0.
- R8: Every JTAG command is refused while fuse bit 9 is 1. The parallel port is never refused for port reasons.
- R9: wdt_force is high when fuse bit 7 is 0. wdt_active is high when wdt_force is high; otherwise it follows the wdt_sw_en input.
- R10: reset_vec equals BOOT_START when fuse bit 8 is 0, and 0 otherwise.
- R11: Op codes are 0 read fuse, 1 write fuse, 2 read program, 3 write program, 4 read data, 5 write data, 6 write lock, 7 erase. Read fuse returns the fuse word when addr bit 0 is 0, and {all ones, lock} when it is 1. Memory addresses wrap modulo the memory depth. Writes return rdata=0.
- R12: compat_mode is high when fuse bit 11 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 3 | Request per port, held until done |
| cmd_op | input | 9 | Op code per port, 3 bits each |
| cmd_addr | input | 3*AW | Address per port |
| cmd_wdata | input | 3*DW | Write data per port |
| cmd_done | output | 3 | One-cycle completion pulse per port |
| cmd_ok | output | 3 | Accepted status, valid with done |
| cmd_rdata | output | 3*DW | Read data per port |
| wdt_sw_en | input | 1 | Software watchdog enable request |
| clk_src | output | 4 | Decoded clock select |
| start_dly | output | 2 | Decoded start-up delay select |
| wdt_force | output | 1 | Watchdog forced on by fuse |
| wdt_active | output | 1 | Effective watchdog enable |
| compat_mode | output | 1 | Compatibility mode active |
| reset_vec | output | RVW | Reset vector address |

## Verification
Most internal errors in this block surface within two cycles at the ports. A corrupted fuse register appears on the decoded outputs one cycle after the done pulse, and it also appears on the next fuse read from any port. A wrong lock value turns the next memory access into a refusal, or into an acceptance, so the error shows as a flipped ok bit together with rdata. A memory word written to the wrong place stays hidden until that address is read again. For that reason the random phase mixes writes with read-backs over a small address range.

// File: rtl/cfg_fuse_pkg.sv
package cfg_fuse_pkg;
    localparam int NPORT  = 3;
    localparam int PIDX_W = 2;
    localparam int FW     = 16;
    localparam int P_PAR  = 0;
    localparam int P_JTG  = 1;
    localparam int P_ISP  = 2;

    typedef enum logic [2:0] {
        OP_RD_FUSE = 3'd0,
        OP_WR_FUSE = 3'd1,
        OP_RD_PROG = 3'd2,
        OP_WR_PROG = 3'd3,
        OP_RD_DATA = 3'd4,
        OP_WR_DATA = 3'd5,
        OP_WR_LOCK = 3'd6,
        OP_ERASE   = 3'd7
    } op_e;

    // programmed = 0 for every single-bit field
    typedef struct packed {
        logic [3:0] spare;
        logic       compat_n;
        logic       isp_off;
        logic       jtag_off;
        logic       boot_sel_n;
        logic       wdt_lock_n;
        logic       rst_io_n;
        logic [1:0] sut;
        logic [3:0] cksel;
    } fuse_t;

    localparam logic [FW-1:0] FUSE_DEFAULT = 16'hF1E1;
    localparam logic [FW-1:0] FUSE_SPARE   = 16'hF000;
    localparam logic [1:0]    LOCK_OPEN    = 2'b11;

    function automatic logic port_open(input logic [PIDX_W-1:0] p, input fuse_t f);
        logic r;
        case (p)
            PIDX_W'(P_JTG): r = !f.jtag_off;
            PIDX_W'(P_ISP): r = !f.isp_off && f.rst_io_n;
            default:        r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic op_needs_unlock(input op_e op);
        return (op == OP_WR_FUSE) || (op == OP_RD_PROG) || (op == OP_WR_PROG)
            || (op == OP_RD_DATA) || (op == OP_WR_DATA);
    endfunction
endpackage

// File: rtl/cfg_port_arb.sv
module cfg_port_arb #(
    parameter int N   = 3,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   req,
    output logic           valid,
    output logic [IDW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDW'(i);
        end
    end
endmodule

// File: rtl/cfg_access_rules.sv
module cfg_access_rules
    import cfg_fuse_pkg::*;
(
    input  logic [PIDX_W-1:0] port,
    input  op_e               op,
    input  fuse_t             fuse,
    input  logic [1:0]        lock,
    output logic              accept
);
    logic locked;
    always_comb begin
        locked = (lock != LOCK_OPEN);
        accept = port_open(port, fuse) && !(locked && op_needs_unlock(op));
    end
endmodule

// File: rtl/cfg_nvm_store.sv
module cfg_nvm_store
    import cfg_fuse_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int PROG_DEPTH = 16,
    parameter int DATA_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output fuse_t         fuse_q,
    output logic [1:0]    lock_q,
    output logic [DW-1:0] rd_word
);
    localparam int PIW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
    localparam int DIW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;

    logic [DW-1:0] prog_mem [PROG_DEPTH];
    logic [DW-1:0] data_mem [DATA_DEPTH];
    logic [PIW-1:0] pidx;
    logic [DIW-1:0] didx;

    always_comb begin
        pidx = PIW'(32'(addr) % PROG_DEPTH);
        didx = DIW'(32'(addr) % DATA_DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q <= fuse_t'(FUSE_DEFAULT);
            lock_q <= LOCK_OPEN;
            for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= '0;
            for (int i = 0; i < DATA_DEPTH; i++) data_mem[i] <= '0;
        end else if (exec) begin
            case (op)
                OP_WR_FUSE: fuse_q <= fuse_t'(wdata[FW-1:0] | FUSE_SPARE);
                OP_WR_PROG: prog_mem[pidx] <= wdata;
                OP_WR_DATA: data_mem[didx] <= wdata;
                OP_WR_LOCK: lock_q <= lock_q & wdata[1:0];
                OP_ERASE: begin
                    lock_q <= LOCK_OPEN;
                    for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= '0;
                    for (int i = 0; i < DATA_DEPTH; i++) data_mem[i] <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (op)
            OP_RD_FUSE: begin
                rd_word = '1;
                if (addr[0]) rd_word[1:0] = lock_q;
                else         rd_word[FW-1:0] = fuse_q;
            end
            OP_RD_PROG: rd_word = prog_mem[pidx];
            OP_RD_DATA: rd_word = data_mem[didx];
            default:    rd_word = '0;
        endcase
    end
endmodule

// File: rtl/cfg_fuse_decode.sv
module cfg_fuse_decode
    import cfg_fuse_pkg::*;
#(
    parameter int               RVW        = 16,
    parameter logic [RVW-1:0]   BOOT_START = 16'hF000
) (
    input  logic           clk,
    input  logic           rst,
    input  fuse_t          fuse,
    input  logic           wdt_sw_en,
    output logic [3:0]     clk_src,
    output logic [1:0]     start_dly,
    output logic           wdt_force,
    output logic           wdt_active,
    output logic           compat_mode,
    output logic [RVW-1:0] reset_vec
);
    localparam fuse_t DEF = fuse_t'(FUSE_DEFAULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_src     <= DEF.cksel;
            start_dly   <= DEF.sut;
            wdt_force   <= !DEF.wdt_lock_n;
            compat_mode <= !DEF.compat_n;
            reset_vec   <= DEF.boot_sel_n ? '0 : BOOT_START;
        end else begin
            clk_src     <= fuse.cksel;
            start_dly   <= fuse.sut;
            wdt_force   <= !fuse.wdt_lock_n;
            compat_mode <= !fuse.compat_n;
            reset_vec   <= fuse.boot_sel_n ? '0 : BOOT_START;
        end
    end

    always_comb wdt_active = wdt_force | wdt_sw_en;
endmodule

// File: rtl/cfg_fuse_ctrl.sv
module cfg_fuse_ctrl
    import cfg_fuse_pkg::*;
#(
    parameter int             AW         = 8,
    parameter int             DW         = 16,
    parameter int             PROG_DEPTH = 16,
    parameter int             DATA_DEPTH = 16,
    parameter int             RVW        = 16,
    parameter logic [RVW-1:0] BOOT_START = 16'hF000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cmd_req,
    input  logic [8:0]          cmd_op,
    input  logic [3*AW-1:0]     cmd_addr,
    input  logic [3*DW-1:0]     cmd_wdata,
    output logic [2:0]          cmd_done,
    output logic [2:0]          cmd_ok,
    output logic [3*DW-1:0]     cmd_rdata,
    input  logic                wdt_sw_en,
    output logic [3:0]          clk_src,
    output logic [1:0]          start_dly,
    output logic                wdt_force,
    output logic                wdt_active,
    output logic                compat_mode,
    output logic [RVW-1:0]      reset_vec
);
    logic [NPORT-1:0]          done_q, ok_q, pend;
    logic [NPORT-1:0][DW-1:0]  rdata_q;
    logic                      g_valid, ex_valid, ex_accept;
    logic [PIDX_W-1:0]         ex_idx;
    op_e                       ex_op;
    logic [AW-1:0]             ex_addr;
    logic [DW-1:0]             ex_wdata, rd_word;
    fuse_t                     fuse_q;
    logic [1:0]                lock_q;

    always_comb pend = cmd_req & ~done_q;

    cfg_port_arb #(.N(NPORT), .IDW(PIDX_W)) u_arb (
        .req(pend), .valid(g_valid), .idx(ex_idx)
    );

    always_comb begin
        ex_valid = g_valid & ~rst;
        ex_op    = op_e'(cmd_op[ex_idx*3 +: 3]);
        ex_addr  = cmd_addr[ex_idx*AW +: AW];
        ex_wdata = cmd_wdata[ex_idx*DW +: DW];
    end

    cfg_access_rules u_rules (
        .port(ex_idx), .op(ex_op), .fuse(fuse_q), .lock(lock_q), .accept(ex_accept)
    );

    cfg_nvm_store #(.AW(AW), .DW(DW), .PROG_DEPTH(PROG_DEPTH), .DATA_DEPTH(DATA_DEPTH)) u_store (
        .clk(clk), .rst(rst), .exec(ex_valid & ex_accept), .op(ex_op),
        .addr(ex_addr), .wdata(ex_wdata), .fuse_q(fuse_q), .lock_q(lock_q), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= '0;
            ok_q    <= '0;
            rdata_q <= '0;
        end else begin
            done_q <= '0;
            ok_q   <= '0;
            if (ex_valid) begin
                done_q[ex_idx]  <= 1'b1;
                ok_q[ex_idx]    <= ex_accept;
                rdata_q[ex_idx] <= ex_accept ? rd_word : '0;
            end
        end
    end

    always_comb begin
        cmd_done  = done_q;
        cmd_ok    = ok_q;
        cmd_rdata = rdata_q;
    end

    cfg_fuse_decode #(.RVW(RVW), .BOOT_START(BOOT_START)) u_dec (
        .clk(clk), .rst(rst), .fuse(fuse_q), .wdt_sw_en(wdt_sw_en),
        .clk_src(clk_src), .start_dly(start_dly), .wdt_force(wdt_force),
        .wdt_active(wdt_active), .compat_mode(compat_mode), .reset_vec(reset_vec)
    );
endmodule

// File: rtl/cfg_fuse_ctrl_sva.sv
module cfg_fuse_ctrl_sva (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cmd_req,
    input logic [2:0]  cmd_done,
    input logic [2:0]  cmd_ok,
    input logic        wdt_force,
    input logic        wdt_active,
    input logic        compat_mode,
    input logic [15:0] fuse_q,
    input logic [1:0]  lock_q,
    input logic        ex_valid,
    input logic        ex_accept,
    input logic [1:0]  ex_idx,
    input logic [2:0]  ex_op
);
    assert_one_done_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_done));

    assert_ok_with_done_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok & ~cmd_done) == 3'b000);

    assert_par_first_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_req[0] && !cmd_done[0]) |-> (ex_valid && ex_idx == 2'd0));

    assert_reject_still_R4: assert property (@(posedge clk) disable iff (rst)
        $past(ex_valid && !ex_accept) |-> (fuse_q == $past(fuse_q) && lock_q == $past(lock_q)));

    assert_lock_mem_R5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_done != 3'b000) && $past(lock_q != 2'b11 && ex_op >= 3'd1 && ex_op <= 3'd5))
        |-> (cmd_ok == 3'b000));

    assert_erase_keep_R6: assert property (@(posedge clk) disable iff (rst)
        $past(ex_valid && ex_accept && ex_op == 3'd7)
        |-> (lock_q == 2'b11 && fuse_q == $past(fuse_q)));

    assert_isp_off_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_done[2] && $past(fuse_q[10] || !fuse_q[6])) |-> !cmd_ok[2]);

    assert_jtag_off_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_done[1] && $past(fuse_q[9])) |-> !cmd_ok[1]);

    assert_wdt_force_R9: assert property (@(posedge clk) disable iff (rst)
        wdt_force |-> wdt_active);

    assert_compat_lag_R12: assert property (@(posedge clk) disable iff (rst)
        compat_mode == !$past(fuse_q[11]));
endmodule

bind cfg_fuse_ctrl cfg_fuse_ctrl_sva u_sva (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
    .wdt_force(wdt_force), .wdt_active(wdt_active), .compat_mode(compat_mode),
    .fuse_q(fuse_q), .lock_q(lock_q), .ex_valid(ex_valid), .ex_accept(ex_accept),
    .ex_idx(ex_idx), .ex_op(ex_op)
);

// File: tb/cfg_fuse_ctrl_bench.sv
module cfg_fuse_ctrl_bench;
    localparam int AW = 8, DW = 16, PD = 16, DD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_req = '0;
    logic [8:0]  cmd_op = '0;
    logic [3*AW-1:0] cmd_addr = '0;
    logic [3*DW-1:0] cmd_wdata = '0;
    logic [2:0]  cmd_done, cmd_ok;
    logic [3*DW-1:0] cmd_rdata;
    logic        wdt_sw_en = 1'b0;
    logic [3:0]  clk_src;
    logic [1:0]  start_dly;
    logic        wdt_force, wdt_active, compat_mode;
    logic [15:0] reset_vec;

    int checks = 0, errors = 0, cycles = 0;

    logic [15:0] m_fuse;
    logic [1:0]  m_lock;
    logic [15:0] m_prog [PD];
    logic [15:0] m_data [DD];

    cfg_fuse_ctrl u_cfg_fuse_ctrl (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .cmd_rdata(cmd_rdata),
        .wdt_sw_en(wdt_sw_en), .clk_src(clk_src), .start_dly(start_dly),
        .wdt_force(wdt_force), .wdt_active(wdt_active), .compat_mode(compat_mode),
        .reset_vec(reset_vec)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            summary();
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_ok(int p, int op, logic [15:0] fz, logic [1:0] lk);
        bit port_on;
        port_on = (p == 0) || (p == 1 && !fz[9]) || (p == 2 && !fz[10] && fz[6]);
        if (!port_on) return 0;
        if (lk != 2'b11 && op >= 1 && op <= 5) return 0;
        return 1;
    endfunction

    task automatic check_decode(input string tag);
        chk(clk_src == m_fuse[3:0], {tag, " R2 clk_src"}, 32'(clk_src), 32'(m_fuse[3:0]));
        chk(start_dly == m_fuse[5:4], {tag, " R2 start_dly"}, 32'(start_dly), 32'(m_fuse[5:4]));
        chk(wdt_force == !m_fuse[7], {tag, " R9 wdt_force"}, 32'(wdt_force), 32'(!m_fuse[7]));
        chk(wdt_active == (!m_fuse[7] || wdt_sw_en), {tag, " R9 wdt_active"},
            32'(wdt_active), 32'(!m_fuse[7] || wdt_sw_en));
        chk(reset_vec == (m_fuse[8] ? 16'h0000 : 16'hF000), {tag, " R10 reset_vec"},
            32'(reset_vec), m_fuse[8] ? 32'h0 : 32'hF000);
        chk(compat_mode == !m_fuse[11], {tag, " R12 compat_mode"}, 32'(compat_mode), 32'(!m_fuse[11]));
    endtask

    task automatic do_cmd(input int p, input int op, input logic [7:0] addr,
                          input logic [15:0] wd, input string tag);
        bit eok;
        logic [15:0] erd;
        int wait_n;
        eok = exp_ok(p, op, m_fuse, m_lock);
        erd = 16'h0;
        if (eok) begin
            case (op)
                0: erd = addr[0] ? {14'h3FFF, m_lock} : m_fuse;
                2: erd = m_prog[addr % PD];
                4: erd = m_data[addr % DD];
                default: erd = 16'h0;
            endcase
        end
        @(negedge clk);
        cmd_req[p] = 1'b1;
        cmd_op[p*3 +: 3] = op[2:0];
        cmd_addr[p*AW +: AW] = addr;
        cmd_wdata[p*DW +: DW] = wd;
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
        end while (!cmd_done[p] && wait_n < 20);
        chk(cmd_done[p] && wait_n == 1, {tag, " R3 done timing"}, 32'(wait_n), 32'd1);
        chk(cmd_ok[p] == eok, {tag, " R4 ok status"}, 32'(cmd_ok[p]), 32'(eok));
        chk(cmd_rdata[p*DW +: DW] == erd, {tag, " R11 rdata"}, 32'(cmd_rdata[p*DW +: DW]), 32'(erd));
        if (op == 1 && eok)
            chk(clk_src == m_fuse[3:0], {tag, " R2 decode not early"}, 32'(clk_src), 32'(m_fuse[3:0]));
        cmd_req[p] = 1'b0;
        if (eok) begin
            case (op)
                1: m_fuse = wd | 16'hF000;
                3: m_prog[addr % PD] = wd;
                5: m_data[addr % DD] = wd;
                6: m_lock = m_lock & wd[1:0];
                7: begin
                    m_lock = 2'b11;
                    for (int i = 0; i < PD; i++) m_prog[i] = '0;
                    for (int i = 0; i < DD; i++) m_data[i] = '0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check_decode(tag);
    endtask

    initial begin
        int p, op;
        logic [15:0] wd;
        void'($urandom(32'h1F2E3D4C));
        m_fuse = 16'hF1E1;
        m_lock = 2'b11;
        for (int i = 0; i < PD; i++) m_prog[i] = '0;
        for (int i = 0; i < DD; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_done == 3'b000, "R1 no done", 32'(cmd_done), 32'h0);
        check_decode("R1 reset");
        do_cmd(0, 0, 8'h00, 16'h0, "R1 fuse word");
        do_cmd(1, 0, 8'h01, 16'h0, "R1 lock bits");

        // basic memory via ISP and JTAG
        do_cmd(2, 3, 8'h03, 16'hA5A5, "R11 isp wr prog");
        do_cmd(2, 2, 8'h13, 16'h0, "R11 isp rd prog wrap");
        do_cmd(1, 5, 8'h07, 16'h1234, "R11 jtag wr data");
        do_cmd(0, 4, 8'h07, 16'h0, "R11 par rd data");

        // R5 lock, R6 erase
        do_cmd(0, 6, 8'h00, 16'hFFFC, "R5 lock");
        do_cmd(2, 2, 8'h03, 16'h0, "R5 locked read");
        do_cmd(1, 3, 8'h03, 16'hBEEF, "R5 locked write");
        do_cmd(0, 1, 8'h00, 16'h0000, "R5 locked fuse write");
        do_cmd(2, 0, 8'h00, 16'h0, "R5 locked fuse read");
        do_cmd(2, 0, 8'h01, 16'h0, "R5 lock readback");
        do_cmd(1, 7, 8'h00, 16'h0, "R6 erase");
        do_cmd(0, 0, 8'h01, 16'h0, "R6 lock open");
        do_cmd(2, 2, 8'h03, 16'h0, "R6 prog cleared");
        do_cmd(1, 4, 8'h07, 16'h0, "R6 data cleared");
        do_cmd(0, 0, 8'h00, 16'h0, "R6 fuses kept");

        // R7 ISP self lockout, restored by JTAG
        do_cmd(2, 1, 8'h00, 16'h05E1, "R7 isp disables itself");
        do_cmd(2, 0, 8'h00, 16'h0, "R7 isp refused");
        do_cmd(2, 1, 8'h00, 16'h01E1, "R7 isp cannot restore");
        do_cmd(1, 1, 8'h00, 16'h01E1, "R7 jtag restores isp");
        do_cmd(2, 0, 8'h00, 16'h0, "R7 isp back");
        do_cmd(0, 1, 8'h00, 16'h01A1, "R7 reset pin as io");
        do_cmd(2, 0, 8'h00, 16'h0, "R7 isp refused rst io");
        do_cmd(0, 1, 8'h00, 16'h01E1, "R7 restore rst");

        // R8 JTAG self lockout, restored by ISP
        do_cmd(1, 1, 8'h00, 16'h03E1, "R8 jtag disables itself");
        do_cmd(1, 4, 8'h00, 16'h0, "R8 jtag refused");
        do_cmd(2, 1, 8'h00, 16'h01E1, "R8 isp restores jtag");
        do_cmd(1, 0, 8'h00, 16'h0, "R8 jtag back");

        // R9 R10 R12 decode
        wdt_sw_en = 1'b0;
        do_cmd(0, 1, 8'h00, 16'h0E6F, "R9 R10 R12 decode set");
        wdt_sw_en = 1'b1;
        do_cmd(0, 1, 8'h00, 16'h01E1, "R9 sw enable");
        wdt_sw_en = 1'b0;
        @(negedge clk);
        check_decode("R9 sw disable");

        // R3 priority: parallel and ISP together
        @(negedge clk);
        cmd_req = 3'b101;
        cmd_op[0 +: 3] = 3'd3; cmd_addr[0 +: AW] = 8'h05; cmd_wdata[0 +: DW] = 16'h1111;
        cmd_op[6 +: 3] = 3'd3; cmd_addr[16 +: AW] = 8'h05; cmd_wdata[32 +: DW] = 16'h2222;
        @(negedge clk);
        chk(cmd_done == 3'b001 && cmd_ok == 3'b001, "R3 parallel first", 32'(cmd_done), 32'h1);
        cmd_req[0] = 1'b0;
        @(negedge clk);
        chk(cmd_done == 3'b100 && cmd_ok == 3'b100, "R3 isp second", 32'(cmd_done), 32'h4);
        cmd_req[2] = 1'b0;
        m_prog[5] = 16'h2222;
        do_cmd(1, 2, 8'h05, 16'h0, "R3 last writer wins");

        // random phase
        for (int n = 0; n < 400; n++) begin
            p  = $urandom_range(0, 2);
            op = $urandom_range(0, 7);
            if (op == 7 && $urandom_range(0, 3) != 0) op = 3;
            if (op == 6 && $urandom_range(0, 1) != 0) op = 2;
            wd = 16'($urandom);
            if (op == 1 && $urandom_range(0, 1) == 0) wd[10:9] = 2'b00;
            if (op == 1 && $urandom_range(0, 1) == 0) wd[6] = 1'b1;
            wdt_sw_en = 1'($urandom);
            do_cmd(p, op, 8'($urandom_range(0, 40)), wd, "R4 random");
        end
        summary();
    end
endmodule